// File: doc/BRIEF.md
# LCD Geometry Register Block

This block is the register file that a nibble-wide processor bus sees for a bitmap display controller. It claims a 64-nibble window of device addresses, starting at 0x100 by default. It stores the control nibble, the bitmap start address, the line stride extension, the line count and the menu bitmap start address. From these stored values it works out the geometry the scan-out engine needs: enable, pixel shift, nibbles per line, first and last address of the main bitmap, number of lines, and the address range of the menu bitmap.

Several registers span more than one nibble and are written one nibble at a time. The geometry is therefore recomputed from the whole stored state and presented on registered outputs. In the cycle where a new geometry first appears, a one-cycle change strobe is raised. Reading the line-count register does not return the stored count. It returns a free-running scan line number that moves forward on every such read, which lets software watch the raster position.

Top module: `lcd_geom_regs`

## Requirements
- R1: After reset all stored registers are zero, and the outputs show: display off, pixel shift 0, nibbles per line equal to ROW_W, 63 lines, bitmap start 0, bitmap end ROW_W*64, menu range 0 to 0x110, menu inactive, change strobe low and read data 0.
- R2: The control nibble sits at window offset 0x00. Bit 3 drives the display enable and bits 2:0 drive the pixel shift. A read returns the stored nibble.
- R3: The line stride extension is 12 bits, written at offsets 0x25 (bits 3:0), 0x26 (bits 7:4) and 0x27 (bits 11:8). Nibbles per line equals ROW_W plus this value, plus 2 more when the pixel shift exceeds 3, taken modulo 4096.
- R4: The bitmap start is 20 bits, written at offsets 0x20 to 0x24 with the least significant nibble first. The effective start has bit 0 forced to zero. Reads return the stored nibbles unchanged.
- R5: The line count byte is written at offset 0x28 (bits 3:0) and 0x29 (bits 7:4). Its low six bits give the number of lines, except that 0 gives 63.
- R6: The bitmap end equals the effective start plus nibbles per line times (lines + 1), modulo 2^20.
- R7: The menu start is 20 bits, written at offsets 0x30 to 0x34 with the least significant nibble first. The menu end is menu start plus 0x110, modulo 2^20. The menu is active only when the number of lines is not 63.
- R8: A scan counter holds a value in the range -1 to 63 and is -1 after reset. Each read at offset 0x28 or 0x29 first advances the counter, and a counter that would reach 64 returns to -1. The read then yields a byte made of stored line count bits 7:6 and the counter's low six bits, where -1 gives 0x3F. Offset 0x28 returns bits 3:0 of that byte and offset 0x29 returns bits 7:4. Read data appears on the clock edge that takes the read.
- R9: A write to offset 0x28 or 0x29 sets the scan counter to -1. When wr_en and rd_en are both high in the same cycle, only the write is performed: the counter does not advance and the read data holds its value.
- R10: Geometry outputs take their new values on the clock edge after the write. The change strobe is high for exactly that one cycle. A write that leaves every geometry output unchanged, such as changing only start bit 0 or rewriting a value that is already stored, raises no strobe.
- R11: Window offsets not listed above read as 0, and writes to them have no effect. Addresses outside the window are ignored by both reads and writes, and a read there returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 20 | Nibble bus address |
| wr_en | input | 1 | Write strobe |
| wr_nib | input | 4 | Write data nibble |
| rd_en | input | 1 | Read strobe |
| rd_nib | output | 4 | Registered read data |
| disp_on | output | 1 | Display enable |
| pix_ofs | output | 3 | Pixel shift |
| line_nibs | output | 12 | Nibbles per bitmap line |
| disp_start | output | 20 | Effective bitmap start address |
| disp_end | output | 20 | Bitmap end address |
| num_lines | output | 6 | Number of lines |
| menu_start | output | 20 | Menu bitmap start address |
| menu_end | output | 20 | Menu bitmap end address |
| menu_active | output | 1 | Menu region in use |
| geom_chg | output | 1 | One-cycle geometry change strobe |

## Verification
Two functions can fall in the same cycle: a line-count write, which resets the scan counter and may change the geometry, and a scan-counter read at the same address. The bench provokes the overlap by advancing the counter with a few reads and then raising wr_en and rd_en together at offset 0x28. It judges the result two ways. The read data must still hold its previous value in the following cycle, and the next ordinary read must return line 0, which shows the write won and the read did not advance the counter.

// File: rtl/lcd_geom_pkg.sv
// Shared widths, window offsets, the geometry record and the function
// that derives geometry from stored register values.
package lcd_geom_pkg;

    localparam int ADR_W   = 20;  // nibble address width
    localparam int SEL_W   = 3;   // nibble index width within a field
    localparam int OFS_W   = 6;   // offset width within the device window
    localparam int LOFS_W  = 12;  // line stride extension width
    localparam int LCNT_W  = 8;   // stored line count width
    localparam int LINES_W = 6;   // active line field width
    localparam int SCAN_W  = 7;   // scan counter width (value -1 encoded as all ones)

    localparam int N_START = 5;
    localparam int N_LOFS  = 3;
    localparam int N_LCNT  = 2;
    localparam int N_MENU  = 5;

    localparam logic [OFS_W-1:0] OFF_CTL   = 6'h00;
    localparam logic [OFS_W-1:0] OFF_START = 6'h20;
    localparam logic [OFS_W-1:0] OFF_LOFS  = 6'h25;
    localparam logic [OFS_W-1:0] OFF_LCNT  = 6'h28;
    localparam logic [OFS_W-1:0] OFF_MENU  = 6'h30;

    localparam logic [ADR_W-1:0] MENU_SPAN = 20'h00110;

    typedef struct packed {
        logic               en;
        logic [2:0]         ofs;
        logic [LOFS_W-1:0]  nibs;
        logic [ADR_W-1:0]   start;
        logic [ADR_W-1:0]   stop;
        logic [LINES_W-1:0] lines;
        logic [ADR_W-1:0]   mstart;
        logic [ADR_W-1:0]   mstop;
    } geom_t;

    // Derive the full geometry record from the stored register contents.
    function automatic geom_t geom_of(input logic [3:0]        ctl,
                                      input logic [ADR_W-1:0]  start,
                                      input logic [LOFS_W-1:0] lofs,
                                      input logic [LCNT_W-1:0] lcnt,
                                      input logic [ADR_W-1:0]  menu,
                                      input int                row_w);
        geom_t g;
        logic [ADR_W-1:0] rows;
        g.en     = ctl[3];
        g.ofs    = ctl[2:0];
        g.nibs   = LOFS_W'(row_w) + lofs + ((ctl[2:0] > 3'd3) ? LOFS_W'(2) : LOFS_W'(0));
        g.start  = {start[ADR_W-1:1], 1'b0};
        g.lines  = (lcnt[LINES_W-1:0] == '0) ? '1 : lcnt[LINES_W-1:0];
        rows     = ADR_W'(g.lines) + ADR_W'(1);
        g.stop   = g.start + ADR_W'(g.nibs) * rows;
        g.mstart = menu;
        g.mstop  = menu + MENU_SPAN;
        return g;
    endfunction

endpackage

// File: rtl/nib_field.sv
// Multi-nibble storage register written one nibble at a time.
// Assumes the caller has already decoded that the access targets this
// field and that sel is below NIBS.
module nib_field
    import lcd_geom_pkg::*;
#(
    parameter int                NIBS = 1,
    parameter logic [NIBS*4-1:0] RST  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [3:0]        wr_nib,
    output logic [NIBS*4-1:0] value
);

    logic [NIBS-1:0]   we;
    logic [NIBS*4-1:0] value_q;

    // One write enable per nibble lane.
    for (genvar g = 0; g < NIBS; g++) begin : g_we
        assign we[g] = wr_en && (sel == SEL_W'(g));
    end

    // Store the addressed nibble; reset loads the field default.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= RST;
        end else begin
            for (int i = 0; i < NIBS; i++) begin
                if (we[i]) value_q[i*4 +: 4] <= wr_nib;
            end
        end
    end

    assign value = value_q;

endmodule

// File: rtl/scan_ctr.sv
// Raster line counter seen through line-count reads. Holds -1 (all ones)
// or 0..63. Advance runs before the value is used, and clear wins over
// advance. nxt_lo is the low six bits the current read returns.
module scan_ctr
    import lcd_geom_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv,
    input  logic               clr,
    output logic [LINES_W-1:0] nxt_lo
);

    localparam logic [SCAN_W-1:0] IDLE = '1;
    localparam logic [SCAN_W-1:0] TOP  = SCAN_W'(1 << LINES_W);

    logic [SCAN_W-1:0] cnt_q, cnt_inc, cnt_nxt;

    // Step value with wrap from 63 back to -1.
    always_comb begin
        cnt_inc = cnt_q + SCAN_W'(1);
        cnt_nxt = (cnt_inc == TOP) ? IDLE : cnt_inc;
    end

    // Counter register: clear on reset or line-count write, else advance on read.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= IDLE;
        else if (adv)      cnt_q <= cnt_nxt;
    end

    assign nxt_lo = cnt_nxt[LINES_W-1:0];

    // R8: counter never leaves the legal range
    a_r8_scan_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q < TOP) || (cnt_q == IDLE));

    // R9: a line-count write leaves the counter at -1
    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == IDLE));

endmodule

// File: rtl/geom_track.sv
// Registers the derived geometry and raises a one-cycle strobe in the
// cycle where a new value first shows. Assumes reset is held for at least
// two clock edges.
module geom_track
    import lcd_geom_pkg::*;
#(
    parameter int ROW_W = 34
) (
    input  logic  clk,
    input  logic  rst_n,
    input  geom_t cur,
    output geom_t geom_q,
    output logic  chg
);

    localparam geom_t RST_G = geom_of('0, '0, '0, '0, '0, ROW_W);

    // Capture new geometry and flag any difference from the held copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            geom_q <= RST_G;
            chg    <= 1'b0;
        end else begin
            geom_q <= cur;
            chg    <= (cur != geom_q);
        end
    end

    // R10: a strobe always marks an actual change of the outputs
    a_r10_pulse_means_change: assert property (@(posedge clk) disable iff (!rst_n)
        chg |-> (geom_q != $past(geom_q)));

    // R10: without a strobe the outputs hold still
    a_r10_quiet_means_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !chg |-> $stable(geom_q));

endmodule

// File: rtl/lcd_geom_regs.sv
// Register window of the bitmap display controller. Decodes the 64-nibble
// device window, stores the geometry registers, returns registered read
// data and publishes the derived geometry. Assumes at most one bus address
// per cycle; a write wins over a read in the same cycle.
module lcd_geom_regs
    import lcd_geom_pkg::*;
#(
    parameter int               ROW_W    = 34,
    parameter logic [ADR_W-1:0] DEV_BASE = 20'h00100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADR_W-1:0]   bus_addr,
    input  logic               wr_en,
    input  logic [3:0]         wr_nib,
    input  logic               rd_en,
    output logic [3:0]         rd_nib,
    output logic               disp_on,
    output logic [2:0]         pix_ofs,
    output logic [LOFS_W-1:0]  line_nibs,
    output logic [ADR_W-1:0]   disp_start,
    output logic [ADR_W-1:0]   disp_end,
    output logic [LINES_W-1:0] num_lines,
    output logic [ADR_W-1:0]   menu_start,
    output logic [ADR_W-1:0]   menu_end,
    output logic               menu_active,
    output logic               geom_chg
);

    logic [ADR_W-1:0] rel;
    logic [OFS_W-1:0] off;
    logic             in_win, do_rd;
    logic             hit_ctl, hit_start, hit_lofs, hit_lcnt, hit_menu;
    logic [SEL_W-1:0] sel_start, sel_lofs, sel_lcnt, sel_menu;

    logic [3:0]              ctl_q;
    logic [N_START*4-1:0]    start_q;
    logic [N_LOFS*4-1:0]     lofs_q;
    logic [N_LCNT*4-1:0]     lcnt_q;
    logic [N_MENU*4-1:0]     menu_q;
    logic [LINES_W-1:0]      scan_lo;
    logic [7:0]              scan_byte;
    logic [3:0]              rd_mux;
    logic [3:0]              rd_q;
    geom_t                   geom_cur, geom_q;

    // Window and field decode.
    always_comb begin
        rel       = bus_addr - DEV_BASE;
        in_win    = (rel[ADR_W-1:OFS_W] == '0);
        off       = rel[OFS_W-1:0];
        hit_ctl   = in_win && (off == OFF_CTL);
        hit_start = in_win && (off >= OFF_START) && (off < OFF_START + OFS_W'(N_START));
        hit_lofs  = in_win && (off >= OFF_LOFS)  && (off < OFF_LOFS  + OFS_W'(N_LOFS));
        hit_lcnt  = in_win && (off >= OFF_LCNT)  && (off < OFF_LCNT  + OFS_W'(N_LCNT));
        hit_menu  = in_win && (off >= OFF_MENU)  && (off < OFF_MENU  + OFS_W'(N_MENU));
        sel_start = SEL_W'(off - OFF_START);
        sel_lofs  = SEL_W'(off - OFF_LOFS);
        sel_lcnt  = SEL_W'(off - OFF_LCNT);
        sel_menu  = SEL_W'(off - OFF_MENU);
        do_rd     = rd_en && !wr_en;
    end

    nib_field #(.NIBS(1)) u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en && hit_ctl), .sel('0),
        .wr_nib(wr_nib), .value(ctl_q));

    nib_field #(.NIBS(N_START)) u_start (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en && hit_start), .sel(sel_start),
        .wr_nib(wr_nib), .value(start_q));

    nib_field #(.NIBS(N_LOFS)) u_lofs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en && hit_lofs), .sel(sel_lofs),
        .wr_nib(wr_nib), .value(lofs_q));

    nib_field #(.NIBS(N_LCNT)) u_lcnt (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en && hit_lcnt), .sel(sel_lcnt),
        .wr_nib(wr_nib), .value(lcnt_q));

    nib_field #(.NIBS(N_MENU)) u_menu (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en && hit_menu), .sel(sel_menu),
        .wr_nib(wr_nib), .value(menu_q));

    scan_ctr u_scan (
        .clk(clk), .rst_n(rst_n), .adv(do_rd && hit_lcnt),
        .clr(wr_en && hit_lcnt), .nxt_lo(scan_lo));

    // Geometry derived from the stored fields.
    always_comb geom_cur = geom_of(ctl_q, start_q, lofs_q, lcnt_q, menu_q, ROW_W);

    geom_track #(.ROW_W(ROW_W)) u_geom (
        .clk(clk), .rst_n(rst_n), .cur(geom_cur), .geom_q(geom_q), .chg(geom_chg));

    // Read data selection, scan byte included.
    always_comb begin
        scan_byte = {lcnt_q[LCNT_W-1:LINES_W], scan_lo};
        rd_mux    = 4'h0;
        if (hit_ctl)        rd_mux = ctl_q;
        else if (hit_start) rd_mux = start_q[4*int'(sel_start) +: 4];
        else if (hit_lofs)  rd_mux = lofs_q[4*int'(sel_lofs) +: 4];
        else if (hit_lcnt)  rd_mux = sel_lcnt[0] ? scan_byte[7:4] : scan_byte[3:0];
        else if (hit_menu)  rd_mux = menu_q[4*int'(sel_menu) +: 4];
    end

    // Read data register, loaded only on a read that is not overridden by a write.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_q <= 4'h0;
        else if (do_rd) rd_q <= rd_mux;
    end

    assign rd_nib      = rd_q;
    assign disp_on     = geom_q.en;
    assign pix_ofs     = geom_q.ofs;
    assign line_nibs   = geom_q.nibs;
    assign disp_start  = geom_q.start;
    assign disp_end    = geom_q.stop;
    assign num_lines   = geom_q.lines;
    assign menu_start  = geom_q.mstart;
    assign menu_end    = geom_q.mstop;
    assign menu_active = (geom_q.lines != '1);

    // R5: the published line count is never zero
    a_r5_lines_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        num_lines != '0);

    // R7: menu range always spans the fixed length
    a_r7_menu_span: assert property (@(posedge clk) disable iff (!rst_n)
        (menu_end - menu_start) == MENU_SPAN);

    // R11: writes outside the window leave every stored field alone
    a_r11_outside_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !in_win) |=> ($stable(ctl_q) && $stable(start_q) && $stable(lofs_q)
                                && $stable(lcnt_q) && $stable(menu_q)));

endmodule

// File: tb/sim_lcd_geom_regs.sv
module sim_lcd_geom_regs;

    localparam int ROW = 34;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] bus_addr = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_nib = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_nib;
    logic        disp_on;
    logic [2:0]  pix_ofs;
    logic [11:0] line_nibs;
    logic [19:0] disp_start, disp_end, menu_start, menu_end;
    logic [5:0]  num_lines;
    logic        menu_active, geom_chg;

    int n_chk = 0;
    int n_fail = 0;
    int pulses = 0;

    // reference model state
    int m_ctl = 0, m_start = 0, m_lofs = 0, m_lcnt = 0, m_menu = 0, m_scan = -1;

    always #5 clk = ~clk;

    lcd_geom_regs #(.ROW_W(ROW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en), .wr_nib(wr_nib),
        .rd_en(rd_en), .rd_nib(rd_nib), .disp_on(disp_on), .pix_ofs(pix_ofs),
        .line_nibs(line_nibs), .disp_start(disp_start), .disp_end(disp_end),
        .num_lines(num_lines), .menu_start(menu_start), .menu_end(menu_end),
        .menu_active(menu_active), .geom_chg(geom_chg));

    always @(negedge clk) if (rst_n && geom_chg) pulses++;

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int put_nib(input int v, input int idx, input int d);
        return (v & ~(15 << (4*idx))) | ((d & 15) << (4*idx));
    endfunction

    function automatic int e_nibs();
        return (ROW + m_lofs + (((m_ctl & 7) > 3) ? 2 : 0)) & 'hFFF;
    endfunction
    function automatic int e_lines();
        return ((m_lcnt & 63) == 0) ? 63 : (m_lcnt & 63);
    endfunction
    function automatic int e_end();
        return ((m_start & 'hFFFFE) + e_nibs() * (e_lines() + 1)) & 'hFFFFF;
    endfunction

    // Model of the register write effect.
    task automatic model_wr(input int a, input int d);
        int off;
        if (a >= 'h100 && a < 'h140) begin
            off = a - 'h100;
            if (off == 0) m_ctl = d;
            else if (off >= 'h20 && off < 'h25) m_start = put_nib(m_start, off - 'h20, d);
            else if (off >= 'h25 && off < 'h28) m_lofs = put_nib(m_lofs, off - 'h25, d);
            else if (off >= 'h28 && off < 'h2A) begin
                m_lcnt = put_nib(m_lcnt, off - 'h28, d);
                m_scan = -1;
            end
            else if (off >= 'h30 && off < 'h35) m_menu = put_nib(m_menu, off - 'h30, d);
        end
    endtask

    // Expected read value; advances the model scan counter on line-count reads.
    function automatic int model_rd(input int a);
        int off, b;
        if (!(a >= 'h100 && a < 'h140)) return 0;
        off = a - 'h100;
        if (off == 0) return m_ctl;
        if (off >= 'h20 && off < 'h25) return (m_start >> (4*(off-'h20))) & 15;
        if (off >= 'h25 && off < 'h28) return (m_lofs >> (4*(off-'h25))) & 15;
        if (off >= 'h28 && off < 'h2A) begin
            m_scan++;
            if (m_scan > 63) m_scan = -1;
            b = (m_lcnt & 'hC0) | (m_scan & 63);
            return (b >> (4*(off-'h28))) & 15;
        end
        if (off >= 'h30 && off < 'h35) return (m_menu >> (4*(off-'h30))) & 15;
        return 0;
    endfunction

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_addr = 20'(a); wr_nib = 4'(d); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        model_wr(a, d);
    endtask

    task automatic rd_chk(input string req, input int a);
        int e;
        @(negedge clk);
        bus_addr = 20'(a); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        e = model_rd(a);
        check(req, $sformatf("read %0h", a), 32'(rd_nib), 32'(e));
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic chk_geom(input string req);
        check(req, "disp_on", 32'(disp_on), 32'((m_ctl >> 3) & 1));
        check(req, "pix_ofs", 32'(pix_ofs), 32'(m_ctl & 7));
        check(req, "line_nibs", 32'(line_nibs), 32'(e_nibs()));
        check(req, "disp_start", 32'(disp_start), 32'(m_start & 'hFFFFE));
        check(req, "num_lines", 32'(num_lines), 32'(e_lines()));
        check(req, "disp_end", 32'(disp_end), 32'(e_end()));
        check(req, "menu_start", 32'(menu_start), 32'(m_menu));
        check(req, "menu_end", 32'(menu_end), 32'((m_menu + 'h110) & 'hFFFFF));
        check(req, "menu_active", 32'(menu_active), 32'(e_lines() != 63));
    endtask

    task automatic t_reset();
        check("R1", "line_nibs", 32'(line_nibs), 32'(ROW));
        check("R1", "disp_end", 32'(disp_end), 32'(ROW * 64));
        check("R1", "menu_end", 32'(menu_end), 32'h110);
        check("R1", "geom_chg", 32'(geom_chg), 32'h0);
        check("R1", "rd_nib", 32'(rd_nib), 32'h0);
        chk_geom("R1");
        rd_chk("R1", 'h100);
    endtask

    task automatic t_ctl();
        wr('h100, 'hC);
        check("R10", "no change before next edge", 32'(disp_on), 32'h0);
        @(negedge clk);
        check("R10", "strobe with new value", 32'(geom_chg), 32'h1);
        check("R2", "disp_on", 32'(disp_on), 32'h1);
        check("R3", "line_nibs shift>3", 32'(line_nibs), 32'(ROW + 2));
        @(negedge clk);
        check("R10", "strobe one cycle", 32'(geom_chg), 32'h0);
        chk_geom("R2");
        rd_chk("R2", 'h100);
        wr('h100, 'h3);
        settle();
        chk_geom("R3");
    endtask

    task automatic t_lofs();
        wr('h125, 'hF); wr('h126, 'hF); wr('h127, 'hF);
        settle();
        chk_geom("R3");
        check("R3", "wrapped stride", 32'(line_nibs), 32'(ROW - 1));
        wr('h100, 'h4);
        settle();
        chk_geom("R3");
        rd_chk("R3", 'h126);
        wr('h127, 'h0); wr('h126, 'h1); wr('h125, 'h6);
        settle();
        chk_geom("R3");
    endtask

    task automatic t_start();
        wr('h120, 'h5); wr('h121, 'h4); wr('h122, 'h3); wr('h123, 'h2); wr('h124, 'h1);
        settle();
        chk_geom("R4");
        check("R4", "bit0 cleared", 32'(disp_start), 32'h12344);
        rd_chk("R4", 'h120);
        rd_chk("R4", 'h124);
        chk_geom("R6");
    endtask

    task automatic t_lines();
        wr('h128, 'h5); wr('h129, 'hC);
        settle();
        chk_geom("R5");
        check("R7", "menu active", 32'(menu_active), 32'h1);
        chk_geom("R6");
        wr('h128, 'h0); wr('h129, 'h4);
        settle();
        check("R5", "zero gives 63", 32'(num_lines), 32'd63);
        check("R7", "menu inactive", 32'(menu_active), 32'h0);
        chk_geom("R6");
        wr('h128, 'h5); wr('h129, 'hC);
        settle();
    endtask

    task automatic t_menu();
        for (int i = 0; i < 5; i++) wr('h130 + i, 'hF);
        settle();
        chk_geom("R7");
        check("R7", "menu end wrap", 32'(menu_end), 32'h0010F);
        rd_chk("R7", 'h133);
    endtask

    task automatic t_scan();
        wr('h129, 'hC);
        for (int i = 0; i < 67; i++) rd_chk("R8", 'h128);
        for (int i = 0; i < 20; i++) rd_chk("R8", 'h129);
        wr('h128, 'h5);
        rd_chk("R9", 'h128);
    endtask

    task automatic t_collide();
        logic [3:0] prev;
        rd_chk("R8", 'h128); rd_chk("R8", 'h128); rd_chk("R8", 'h128);
        prev = rd_nib;
        @(negedge clk);
        bus_addr = 20'h128; wr_nib = 4'h5; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        model_wr('h128, 'h5);
        check("R9", "read data held on collision", 32'(rd_nib), 32'(prev));
        rd_chk("R9", 'h128);
        check("R9", "first line after clear", 32'(rd_nib), 32'h0);
    endtask

    task automatic t_pulse();
        int p0;
        p0 = pulses;
        wr('h120, (m_start & 15) ^ 1);
        settle();
        check("R10", "bit0 only: no strobe", 32'(pulses - p0), 32'h0);
        rd_chk("R4", 'h120);
        p0 = pulses;
        wr('h100, m_ctl);
        settle();
        check("R10", "same value: no strobe", 32'(pulses - p0), 32'h0);
        p0 = pulses;
        wr('h100, 'hA);
        settle();
        check("R10", "one strobe per change", 32'(pulses - p0), 32'h1);
        chk_geom("R10");
    endtask

    task automatic t_unmapped();
        wr('h110, 'hA);
        rd_chk("R11", 'h110);
        wr('h13F, 'h7);
        rd_chk("R11", 'h13F);
        wr('h1120, 'h9);
        wr('h0FF, 'h3);
        wr('h1100, 'hF);
        settle();
        chk_geom("R11");
        rd_chk("R11", 'h120);
        rd_chk("R11", 'h100);
        rd_chk("R11", 'h1100);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctl();
        t_lofs();
        t_start();
        t_lines();
        t_menu();
        t_scan();
        t_collide();
        t_pulse();
        t_unmapped();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule